// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block drives raw command sequences onto an 8-bit asynchronous NAND flash bus. Software first loads the address bytes and the second-command opcode through a small 32-bit register bus. It then writes a command word. Each phase has its own enable bit in that word. The enabled phases run in a fixed order: first opcode, a chosen number of address bytes, second opcode, and a wait for the ready/busy line to read high.

Each byte is placed on the bus with CLE (opcodes) or ALE (address bytes) high and is latched by a WE# low pulse. The pulse has a fixed width and fixed setup and hold times, all counted in clock cycles. When the last enabled phase ends, the block sets a sticky completion flag that software clears by writing a one. The control register has an enable bit and a controller-reset bit that clears itself. Data transfer, error correction and timing configuration are handled elsewhere.

Top module: `nand_cmd_seq`

## Requirements
- R1: After rst_n is released, the control and status registers read 0, CE# and WE# are high, and CLE and ALE are low.
- R2: Writing 1 to control bit 1 sets that bit. It reads back as 1 until RST_CYCLES cycles have passed and then returns to 0. The enable bit (bit 0) keeps the value written with it, and the completion flag is cleared.
- R3: A write to the command register (offset 0x24) while control bit 0 is 0 starts nothing: no byte appears on the bus and the busy flag stays 0.
- R4: Enabled phases run in this order: first opcode (command bit 22, opcode in command bits 7:0, CLE high), address bytes (command bit 19, ALE high), second opcode (command bit 24, opcode in bits 7:0 of the register at 0x28, CLE high). CLE and ALE are never high together.
- R5: The address phase sends (command bits 18:16)+1 bytes, least significant first. Bytes 0 to 3 come from the register at 0x14 and byte 4 comes from bits 7:0 of the register at 0x18.
- R6: Each byte is latched by a WE# low pulse of T_PULSE cycles. The first byte of a sequence is driven for T_SETUP cycles before its pulse. Consecutive bytes are separated by T_HOLD+T_SETUP cycles with WE# high. WE# goes low only while CLE or ALE is high.
- R7: When command bit 23 is set, the sequence waits T_WB cycles after its last byte and then stays busy until the synchronized R/B# input reads high.
- R8: Status bit 1 is set when a started sequence ends. A command with no phase enabled ends at once. Writing 1 to status bit 1 clears it; writing 0 leaves it set.
- R9: Status bit 4 (busy) is high from the accepted command write until the sequence ends. A command write while busy is ignored.
- R10: A command word whose type field (bits 31:30) is not 0 is ignored.
- R11: CE# is low whenever the block is busy and high when it is idle.
- R12: The device reset command (0xFF as first opcode, with the wait bit set and no address or second-opcode phase) produces exactly one CLE byte and then waits for ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable strobe, active low |
| nand_re_n | output | 1 | Read enable, held high |
| nand_io_out | output | 8 | Bus byte driven to the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_rb_n | input | 1 | Device ready (1) / busy (0), asynchronous |

## Verification
On every cycle the assertions check the bus-level invariants: CLE and ALE are never high together, WE# is low only under a latch enable, CE# is low whenever the block is busy, and the completion flag is set at the end of a sequence. They also check that the block stays busy while R/B# is low in the wait phase and that a command written while busy or disabled does not start a sequence. Only the bench scenarios show the byte order and values for each mix of phases, the address-count field, the WE# pulse and spacing widths, the write-one-to-clear behaviour, and the self-clearing controller reset.

// File: rtl/nsq_pkg.sv
// Shared definitions for the NAND command sequencer: register offsets,
// command-word bit positions, phase and byte-slot types, and the phase
// ordering function. Assumes a byte-addressed 32-bit register bus.
package nsq_pkg;

    localparam logic [7:0] OFF_CTRL = 8'h00;
    localparam logic [7:0] OFF_STAT = 8'h04;
    localparam logic [7:0] OFF_ALO  = 8'h14;
    localparam logic [7:0] OFF_AHI  = 8'h18;
    localparam logic [7:0] OFF_CMD  = 8'h24;
    localparam logic [7:0] OFF_RCMD = 8'h28;

    localparam int CB_NADDR = 16;
    localparam int CB_ADDR  = 19;
    localparam int CB_CMD1  = 22;
    localparam int CB_WAIT  = 23;
    localparam int CB_CMD2  = 24;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD1, PH_ADDR, PH_CMD2, PH_TWB, PH_RDY
    } phase_e;

    typedef enum logic [1:0] {
        BS_SETUP, BS_PULSE, BS_HOLD
    } slot_e;

    typedef struct packed {
        logic       cmd1_en;
        logic       addr_en;
        logic       cmd2_en;
        logic       wait_en;
        logic [2:0] naddr_m1;
        logic [7:0] op1;
    } cmd_t;

    // Phase that follows p, given the enabled phases of c
    function automatic phase_e next_phase(input phase_e p, input cmd_t c);
        phase_e r;
        r = PH_IDLE;
        if (p == PH_IDLE && c.cmd1_en)
            r = PH_CMD1;
        else if ((p == PH_IDLE || p == PH_CMD1) && c.addr_en)
            r = PH_ADDR;
        else if ((p == PH_IDLE || p == PH_CMD1 || p == PH_ADDR) && c.cmd2_en)
            r = PH_CMD2;
        else if ((p == PH_IDLE || p == PH_CMD1 || p == PH_ADDR || p == PH_CMD2) && c.wait_en)
            r = PH_TWB;
        return r;
    endfunction

endpackage

// File: rtl/nsq_sync.sv
// Multi-stage synchronizer for the asynchronous ready/busy line.
// Resets to 0 (busy) so that a wait never ends on a stale value.
module nsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_q;

    // Shift the input through STAGES flops
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], din};
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/nsq_regs.sv
// Register file: control (enable, self-clearing reset), status (completion
// flag, write-one-to-clear; busy), address bytes, second-opcode set and the
// command word. Produces a start pulse with the decoded command when a
// command write is accepted. Assumes single-cycle writes and combinational reads.
module nsq_regs
    import nsq_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wen,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        seq_busy,
    input  logic        seq_fin,
    output logic        start,
    output cmd_t        cmd_dec,
    output logic [39:0] addr_bytes,
    output logic [7:0]  op2,
    output logic        soft_rst
);
    localparam int RCW = $clog2(RST_CYCLES + 1);
    localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYCLES - 1);

    logic           en_q, rst_pend_q, done_q;
    logic [RCW-1:0] rst_cnt_q;
    logic [31:0]    alo_q, cmd_raw_q;
    logic [7:0]     ahi_q;
    logic [23:0]    rcmd_q;
    logic           wr_ctrl, wr_stat, wr_cmd;

    // Decode write strobes and the command word on the bus
    always_comb begin
        wr_ctrl = bus_wen && bus_addr == OFF_CTRL;
        wr_stat = bus_wen && bus_addr == OFF_STAT;
        wr_cmd  = bus_wen && bus_addr == OFF_CMD;
        start   = wr_cmd && en_q && !seq_busy && !rst_pend_q && bus_wdata[31:30] == 2'b00;
        cmd_dec.cmd1_en  = bus_wdata[CB_CMD1];
        cmd_dec.addr_en  = bus_wdata[CB_ADDR];
        cmd_dec.cmd2_en  = bus_wdata[CB_CMD2];
        cmd_dec.wait_en  = bus_wdata[CB_WAIT];
        cmd_dec.naddr_m1 = bus_wdata[CB_NADDR +: 3];
        cmd_dec.op1      = bus_wdata[7:0];
    end

    // Control register with the self-clearing reset counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0; rst_pend_q <= 1'b0; rst_cnt_q <= '0;
        end else if (wr_ctrl) begin
            en_q <= bus_wdata[0];
            if (bus_wdata[1]) begin
                rst_pend_q <= 1'b1; rst_cnt_q <= '0;
            end
        end else if (rst_pend_q) begin
            if (rst_cnt_q == RST_LAST) rst_pend_q <= 1'b0;
            else                       rst_cnt_q  <= rst_cnt_q + 1'b1;
        end
    end

    // Completion flag: cleared by controller reset, set on finish, W1C
    always_ff @(posedge clk) begin
        if (!rst_n || rst_pend_q)        done_q <= 1'b0;
        else if (seq_fin)                done_q <= 1'b1;
        else if (wr_stat && bus_wdata[1]) done_q <= 1'b0;
    end

    // Plain storage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alo_q <= '0; ahi_q <= '0; rcmd_q <= '0; cmd_raw_q <= '0;
        end else begin
            if (bus_wen && bus_addr == OFF_ALO)  alo_q  <= bus_wdata;
            if (bus_wen && bus_addr == OFF_AHI)  ahi_q  <= bus_wdata[7:0];
            if (bus_wen && bus_addr == OFF_RCMD) rcmd_q <= bus_wdata[23:0];
            if (start)                           cmd_raw_q <= bus_wdata;
        end
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            OFF_CTRL: bus_rdata = {30'd0, rst_pend_q, en_q};
            OFF_STAT: bus_rdata = {27'd0, seq_busy, 2'b00, done_q, 1'b0};
            OFF_ALO:  bus_rdata = alo_q;
            OFF_AHI:  bus_rdata = {24'd0, ahi_q};
            OFF_CMD:  bus_rdata = cmd_raw_q;
            OFF_RCMD: bus_rdata = {8'd0, rcmd_q};
            default:  bus_rdata = '0;
        endcase
    end

    assign addr_bytes = {ahi_q, alo_q};
    assign op2        = rcmd_q[7:0];
    assign soft_rst   = rst_pend_q;
endmodule

// File: rtl/nsq_seq.sv
// Phase sequencer: walks the enabled phases in fixed order, times each bus
// byte as setup / WE# pulse / hold slots, then waits tWB and for ready.
// Latches the command, address bytes and second opcode at start.
// Assumes every timing parameter is at least 1.
module nsq_seq
    import nsq_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 2,
    parameter int T_WB    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        abort,
    input  logic        start,
    input  cmd_t        cmd_in,
    input  logic [39:0] addr_in,
    input  logic [7:0]  op2_in,
    input  logic        rb_ready,
    output logic        busy,
    output logic        fin,
    output logic        in_wait,
    output logic        ce_n,
    output logic        cle,
    output logic        ale,
    output logic        we_n,
    output logic        io_oe,
    output logic [7:0]  io_out
);
    localparam int MAXT_A = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
    localparam int MAXT_B = (T_HOLD > T_WB) ? T_HOLD : T_WB;
    localparam int MAXT   = (MAXT_A > MAXT_B) ? MAXT_A : MAXT_B;
    localparam int CW     = $clog2(MAXT + 1);
    localparam logic [CW-1:0] L_SETUP = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] L_PULSE = CW'(T_PULSE - 1);
    localparam logic [CW-1:0] L_HOLD  = CW'(T_HOLD - 1);
    localparam logic [CW-1:0] L_WB    = CW'(T_WB - 1);

    phase_e        phase_q;
    slot_e         slot_q;
    logic [CW-1:0] tcnt_q, lim_m1;
    logic [2:0]    idx_q;
    cmd_t          cmd_q;
    logic [63:0]   addr_q;
    logic [7:0]    op2_q;
    logic          byte_ph, last_tick, more_addr, slot_end;
    phase_e        after_q, first_ph;

    // Slot limits, successor phases and the finish condition
    always_comb begin
        byte_ph = phase_q == PH_CMD1 || phase_q == PH_ADDR || phase_q == PH_CMD2;
        if (phase_q == PH_TWB) lim_m1 = L_WB;
        else case (slot_q)
            BS_SETUP: lim_m1 = L_SETUP;
            BS_PULSE: lim_m1 = L_PULSE;
            default:  lim_m1 = L_HOLD;
        endcase
        last_tick = tcnt_q == lim_m1;
        more_addr = phase_q == PH_ADDR && idx_q != cmd_q.naddr_m1;
        after_q   = next_phase(phase_q, cmd_q);
        first_ph  = next_phase(PH_IDLE, cmd_in);
        slot_end  = byte_ph && slot_q == BS_HOLD && last_tick;
        fin = !abort && ((phase_q == PH_IDLE && start && first_ph == PH_IDLE)
                      || (slot_end && !more_addr && after_q == PH_IDLE)
                      || (phase_q == PH_RDY && rb_ready));
    end

    // Phase / slot state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE; slot_q <= BS_SETUP; tcnt_q <= '0; idx_q <= '0;
            cmd_q <= '0; addr_q <= '0; op2_q <= '0;
        end else if (abort) begin
            phase_q <= PH_IDLE; slot_q <= BS_SETUP; tcnt_q <= '0; idx_q <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= first_ph;
                    cmd_q   <= cmd_in;
                    addr_q  <= {24'd0, addr_in};
                    op2_q   <= op2_in;
                    slot_q  <= BS_SETUP; tcnt_q <= '0; idx_q <= '0;
                end
                PH_CMD1, PH_ADDR, PH_CMD2: begin
                    if (!last_tick) tcnt_q <= tcnt_q + 1'b1;
                    else begin
                        tcnt_q <= '0;
                        case (slot_q)
                            BS_SETUP: slot_q <= BS_PULSE;
                            BS_PULSE: slot_q <= BS_HOLD;
                            default: begin
                                slot_q <= BS_SETUP;
                                if (more_addr) idx_q <= idx_q + 1'b1;
                                else begin
                                    idx_q   <= '0;
                                    phase_q <= after_q;
                                end
                            end
                        endcase
                    end
                end
                PH_TWB: begin
                    if (last_tick) begin phase_q <= PH_RDY; tcnt_q <= '0; end
                    else tcnt_q <= tcnt_q + 1'b1;
                end
                PH_RDY:  if (rb_ready) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Bus pins decoded from the current phase and slot
    always_comb begin
        busy    = phase_q != PH_IDLE;
        in_wait = phase_q == PH_RDY;
        ce_n    = !busy;
        cle     = phase_q == PH_CMD1 || phase_q == PH_CMD2;
        ale     = phase_q == PH_ADDR;
        io_oe   = byte_ph;
        we_n    = !(byte_ph && slot_q == BS_PULSE);
        case (phase_q)
            PH_CMD1: io_out = cmd_q.op1;
            PH_CMD2: io_out = op2_q;
            PH_ADDR: io_out = addr_q[{idx_q, 3'b000} +: 8];
            default: io_out = 8'h00;
        endcase
    end
endmodule

// File: rtl/nand_cmd_seq.sv
// Top of the NAND command sequencer: register file, ready/busy synchronizer
// and phase sequencer. Read enable is never pulsed by this block.
module nand_cmd_seq
    import nsq_pkg::*;
#(
    parameter int T_SETUP     = 2,
    parameter int T_PULSE     = 3,
    parameter int T_HOLD      = 2,
    parameter int T_WB        = 4,
    parameter int RST_CYCLES  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wen,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic        nand_rb_n
);
    logic        seq_busy, seq_fin, seq_in_wait, start, soft_rst, rb_ready;
    cmd_t        cmd_dec;
    logic [39:0] addr_bytes;
    logic [7:0]  op2;

    nsq_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .seq_busy(seq_busy),
        .seq_fin(seq_fin), .start(start), .cmd_dec(cmd_dec),
        .addr_bytes(addr_bytes), .op2(op2), .soft_rst(soft_rst)
    );

    nsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(nand_rb_n), .dout(rb_ready)
    );

    nsq_seq #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_WB(T_WB)) u_seq (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst), .start(start),
        .cmd_in(cmd_dec), .addr_in(addr_bytes), .op2_in(op2),
        .rb_ready(rb_ready), .busy(seq_busy), .fin(seq_fin),
        .in_wait(seq_in_wait), .ce_n(nand_ce_n), .cle(nand_cle),
        .ale(nand_ale), .we_n(nand_we_n), .io_oe(nand_io_oe),
        .io_out(nand_io_out)
    );

    assign nand_re_n = 1'b1;
endmodule

// File: rtl/nand_cmd_seq_chk.sv
// Property checker for the NAND command sequencer, bound to the top module.
// Observes bus pins, the busy state, the completion flag and the command word.
module nand_cmd_seq_chk
    import nsq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done_flag,
    input logic        in_wait,
    input logic        rb_ready,
    input logic        enable,
    input logic        nand_ce_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        bus_wen,
    input logic [7:0]  bus_addr,
    input logic [31:0] cmd_word
);
    // R4
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R6
    we_under_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (nand_cle || nand_ale));

    // R11
    ce_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !nand_ce_n);

    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    // R7
    hold_for_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !rb_ready) |=> busy);

    // R9
    ignore_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_wen && bus_addr == OFF_CMD) |=> $stable(cmd_word));

    // R3
    ignore_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !busy && bus_wen && bus_addr == OFF_CMD) |=> !busy);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(seq_busy), .done_flag(u_regs.done_q),
    .in_wait(seq_in_wait), .rb_ready(rb_ready), .enable(u_regs.en_q),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .cmd_word(u_regs.cmd_raw_q)
);

// File: tb/nand_cmd_seq_tb.sv
`timescale 1ns/1ps
module nand_cmd_seq_tb;
    localparam int TS = 2, TP = 3, TH = 2, TW = 4, RSTC = 8;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        ce_n, cle, ale, we_n, re_n, io_oe;
    logic [7:0]  io_out;
    logic        rb_n = 1'b1;

    always #10 clk = ~clk;

    nand_cmd_seq #(.T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH), .T_WB(TW),
                   .RST_CYCLES(RSTC), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .nand_ce_n(ce_n),
        .nand_cle(cle), .nand_ale(ale), .nand_we_n(we_n), .nand_re_n(re_n),
        .nand_io_out(io_out), .nand_io_oe(io_oe), .nand_rb_n(rb_n)
    );

    typedef struct { bit is_cmd; logic [7:0] val; } item_t;
    item_t expq[$];

    int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
    bit done_run = 0;
    logic [31:0] sh_alo = 0, sh_ahi = 0, sh_rcmd = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk); bus_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_addr = a; #1; d = bus_rdata;
    endtask

    // Driver: push the bytes the requirements predict, then write the command
    task automatic issue(input logic [31:0] w, input bit runs);
        if (runs) begin
            logic [63:0] ab;
            ab = {24'd0, sh_ahi[7:0], sh_alo};
            if (w[22]) expq.push_back('{1'b1, w[7:0]});
            if (w[19])
                for (int i = 0; i <= int'(w[18:16]); i++) expq.push_back('{1'b0, ab[i*8 +: 8]});
            if (w[24]) expq.push_back('{1'b1, sh_rcmd[7:0]});
        end
        wr(8'h24, w);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] s;
        int k;
        k = 0;
        rd(8'h04, s);
        while (s[4] && k < 3000) begin rd(8'h04, s); k++; end
        check(!s[4], req, s, 32'h0);
        check(expq.size() == 0, req, expq.size(), 0);
    endtask

    // Monitor: pop expected bytes on each WE# rising edge; check pulse spacing
    bit prev_we = 1'b1, first_b = 1'b1;
    int low_cnt = 0, high_cnt = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ce_n) begin first_b = 1'b1; high_cnt = 0; end
            if (prev_we && !we_n) begin
                m_chk++;
                if (high_cnt != (first_b ? TS : TH + TS)) begin
                    m_fail++;
                    $display("FAIL R6 spacing: actual %0d expected %0d", high_cnt, first_b ? TS : TH + TS);
                end
                first_b = 1'b0; low_cnt = 0;
            end
            if (!we_n) low_cnt++;
            else if (!ce_n) high_cnt++;
            if (!prev_we && we_n) begin
                m_chk++;
                if (low_cnt != TP) begin
                    m_fail++;
                    $display("FAIL R6 pulse width: actual %0d expected %0d", low_cnt, TP);
                end
                high_cnt = 1;
                m_chk++;
                if (expq.size() == 0) begin
                    m_fail++;
                    $display("FAIL R3/R4 unexpected byte: actual cle=%b ale=%b %h expected none", cle, ale, io_out);
                end else begin
                    item_t e;
                    e = expq.pop_front();
                    if (cle != e.is_cmd || ale != !e.is_cmd || io_out != e.val || ce_n) begin
                        m_fail++;
                        $display("FAIL R4/R5 byte: actual cle=%b ale=%b %h expected cle=%b %h",
                                 cle, ale, io_out, e.is_cmd, e.val);
                    end
                end
            end
            prev_we = we_n;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", (n_chk + m_chk) - (n_fail + m_fail), n_chk + m_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, d); check(d == 0, "R1 ctrl", d, 0);
        rd(8'h04, d); check(d == 0, "R1 status", d, 0);
        check({ce_n, we_n, cle, ale} == 4'b1100, "R1 pins", {ce_n, we_n, cle, ale}, 4'b1100);

        // R3 disabled: a command starts nothing
        issue(32'h00C000FF, 1'b0);
        rd(8'h04, d); check(d[4] == 0, "R3 busy", d, 0);
        repeat (20) @(negedge clk);
        check(ce_n == 1, "R3 ce", ce_n, 1);

        wr(8'h00, 32'h1);

        // R12 / R7 / R11: device reset waits for ready
        rb_n = 1'b0;
        issue(32'h00C000FF, 1'b1);
        repeat (60) @(negedge clk);
        rd(8'h04, d);
        check(d[4] == 1 && d[1] == 0, "R7 waits for ready", d, 32'h10);
        check(ce_n == 0, "R11 ce low while busy", ce_n, 0);
        check(expq.size() == 0, "R12 single byte", expq.size(), 0);
        rb_n = 1'b1;
        wait_idle("R12 completes");
        rd(8'h04, d); check(d[1] == 1, "R8 done set", d, 32'h2);
        check(ce_n == 1, "R11 ce high when idle", ce_n, 1);

        // R8 write-one-to-clear
        wr(8'h04, 32'h0);
        rd(8'h04, d); check(d[1] == 1, "R8 write 0 keeps", d, 32'h2);
        wr(8'h04, 32'h2);
        rd(8'h04, d); check(d[1] == 0, "R8 write 1 clears", d, 0);

        // R4 / R5 page read: five address bytes, both opcodes
        sh_rcmd = 32'h00E00530; wr(8'h28, sh_rcmd);
        sh_alo = 32'h12340000;  wr(8'h14, sh_alo);
        sh_ahi = 32'h56;        wr(8'h18, sh_ahi);
        rd(8'h28, d); check(d == 32'h00E00530, "R4 opcode set readback", d, 32'h00E00530);
        issue(32'h014C0000, 1'b1);
        wait_idle("R4 R5 page read");

        // R5 two address bytes, different opcodes
        sh_rcmd = 32'hE0; wr(8'h28, sh_rcmd);
        sh_alo = 32'hA1B2C3D4; wr(8'h14, sh_alo);
        issue(32'h01490005, 1'b1);
        wait_idle("R5 two bytes");

        // R4 address phase alone
        issue(32'h00080000, 1'b1);
        wait_idle("R4 address only");

        // R9 command while busy is ignored
        rb_n = 1'b0;
        issue(32'h00C00070, 1'b1);
        repeat (5) @(negedge clk);
        issue(32'h00400011, 1'b0);
        rd(8'h24, d); check(d == 32'h00C00070, "R9 command kept", d, 32'h00C00070);
        repeat (40) @(negedge clk);
        rd(8'h04, d); check(d[4] == 1, "R9 busy held", d, 32'h10);
        rb_n = 1'b1;
        wait_idle("R9 ignored write");

        // R10 non-raw type ignored
        issue(32'h804000AA, 1'b0);
        rd(8'h04, d); check(d[4] == 0, "R10 not started", d, 0);
        repeat (20) @(negedge clk);
        check(expq.size() == 0 && ce_n, "R10 no bus activity", ce_n, 1);

        // R8 empty command ends at once
        wr(8'h04, 32'h2);
        issue(32'h00000000, 1'b1);
        rd(8'h04, d); check(d[1] == 1 && d[4] == 0, "R8 empty command done", d, 32'h2);

        // R2 self-clearing controller reset
        wr(8'h00, 32'h3);
        rd(8'h00, d); check(d == 32'h3, "R2 reset bit set", d, 32'h3);
        repeat (RSTC + 2) @(negedge clk);
        rd(8'h00, d); check(d == 32'h1, "R2 reset bit clears", d, 32'h1);
        rd(8'h04, d); check(d[1] == 0, "R2 done cleared", d, 0);

        repeat (5) @(negedge clk);
        done_run = 1;
        $display("%0d/%0d checks passed", (n_chk + m_chk) - (n_fail + m_fail), n_chk + m_chk);
        $finish;
    end
endmodule